// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns the start of one memory burst into the series of column addresses that the burst visits, one address per clock. A controller pulses a start strobe together with the first column, a three-bit length code and an ordering bit held in its mode settings. The block then presents one column per cycle with a valid flag, and it marks the final address of the burst with a last flag.

Bursts of two, four or eight beats stay inside an aligned block of columns. Their order is either counting upward with wrap inside the block, or the start offset XOR the beat number. A page-long burst counts through every column of the row, wraps past the top column and runs until a stop request ends it. Invalid settings are reported through an error pulse instead of producing addresses. A new start always takes over from a burst that is still running. Data movement, read latency and the storage array belong to other blocks.

Top module: `burst_colgen`

## Requirements
- R1: After reset, valid_o, last_o and err_o are all 0.
- R2: Length codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 valid beats. last_o is 1 only on the final beat, and valid_o drops in the cycle after that beat unless a new start arrives.
- R3: With ilv_i = 0 and length L (2, 4 or 8), beat k outputs (start - start mod L) + ((start mod L + k) mod L). The address wraps inside the aligned block.
- R4: With ilv_i = 1 and length L (2, 4 or 8), beat k outputs (start - start mod L) + ((start mod L) XOR k).
- R5: With length code 000, the single beat outputs the start column whatever the value of ilv_i.
- R6: Length code 111 with ilv_i = 0 gives a page burst. Beat k outputs (start + k) mod 2^COL_W. It never raises last_o and continues until stopped.
- R7: When stop_i is sampled high at a clock edge without start_i, valid_o is 0 from that edge on.
- R8: A start with length code 100, 101 or 110, or with code 111 and ilv_i = 1, produces no beat. err_o is 1 for exactly the one cycle after that start, and any running burst ends.
- R9: The first beat, carrying the start column, appears in the cycle after start_i is sampled. The following beats come on consecutive cycles with no gap.
- R10: start_i sampled during a running burst abandons it and begins the new burst at once. This holds even if stop_i is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst with the settings below |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 upward with wrap, 1 XOR order |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | col_o holds a beat of the burst |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | One-cycle pulse after an invalid start |

## Verification
The hardest cases to reach from the ports are the wrap points. In a block burst, the column falls back to the block base only when the start offset is not zero. In a page burst, the wrap past the top column needs hundreds of consecutive beats. The stimulus therefore sweeps every start column against every block length in both orders, and it runs a page burst from near the top of the row long enough to cross column zero before stopping it. Restarts that overlap a stop, and invalid starts during a running burst, are driven on purpose so that the priority between start and stop can be seen at the ports.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    localparam int unsigned LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_ONE   = 3'b000,
        LEN_TWO   = 3'b001,
        LEN_FOUR  = 3'b010,
        LEN_EIGHT = 3'b011,
        LEN_PAGE  = 3'b111
    } len_code_e;

endpackage

// File: rtl/colgen_decode.sv
module colgen_decode #(
    parameter int unsigned COL_W = 9
) (
    input  logic [colgen_pkg::LEN_CODE_W-1:0] code_i,
    input  logic                              ilv_i,
    output logic [COL_W-1:0]                  mask_o,
    output logic                              page_o,
    output logic                              ok_o
);
    import colgen_pkg::*;

    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        ok_o   = 1'b0;
        case (code_i)
            LEN_ONE:   ok_o = 1'b1;
            LEN_TWO:   begin mask_o = COL_W'(1); ok_o = 1'b1; end
            LEN_FOUR:  begin mask_o = COL_W'(3); ok_o = 1'b1; end
            LEN_EIGHT: begin mask_o = COL_W'(7); ok_o = 1'b1; end
            LEN_PAGE:  begin mask_o = '1; page_o = 1'b1; ok_o = !ilv_i; end
            default:   ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/colgen_step.sv
module colgen_step #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low;

    always_comb begin
        if (ilv_i) begin
            low = base_i ^ beat_i;
        end else begin
            low = base_i + beat_i;
        end
        col_o = (base_i & ~mask_i) | (low & mask_i);
    end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
    parameter int unsigned COL_W = 9
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic [COL_W-1:0]                  start_col_i,
    input  logic [colgen_pkg::LEN_CODE_W-1:0] len_code_i,
    input  logic                              ilv_i,
    input  logic                              stop_i,
    output logic [COL_W-1:0]                  col_o,
    output logic                              valid_o,
    output logic                              last_o,
    output logic                              err_o
);

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             err;
        logic             page;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_ok;
    logic [COL_W-1:0] beat_nx;
    logic [COL_W-1:0] col_nx;

    colgen_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .ilv_i  (ilv_i),
        .mask_o (dec_mask),
        .page_o (dec_page),
        .ok_o   (dec_ok)
    );

    assign beat_nx = st_q.beat + COL_W'(1);

    colgen_step #(.COL_W(COL_W)) u_step (
        .base_i (st_q.base),
        .beat_i (beat_nx),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (start_i) begin
            if (dec_ok) begin
                st_d.valid = 1'b1;
                st_d.page  = dec_page;
                st_d.ilv   = ilv_i;
                st_d.base  = start_col_i;
                st_d.mask  = dec_mask;
                st_d.beat  = '0;
                st_d.col   = start_col_i;
                st_d.last  = !dec_page && (dec_mask == '0);
            end else begin
                st_d.valid = 1'b0;
                st_d.last  = 1'b0;
                st_d.err   = 1'b1;
            end
        end else if (st_q.valid && (stop_i || st_q.last)) begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end else if (st_q.valid) begin
            st_d.beat = beat_nx;
            st_d.col  = col_nx;
            st_d.last = !st_q.page && (beat_nx == st_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o   = st_q.col;
    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;
    assign err_o   = st_q.err;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int unsigned COL_W = 9
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              start_i,
    input logic [COL_W-1:0]                  start_col_i,
    input logic [colgen_pkg::LEN_CODE_W-1:0] len_code_i,
    input logic                              stop_i,
    input logic [COL_W-1:0]                  col_o,
    input logic                              valid_o,
    input logic                              last_o,
    input logic                              err_o
);

    a_r2_last_only_when_valid: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    a_r2_ends_after_last: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    a_r7_stop_ends_burst: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !valid_o);

    a_r8_error_has_no_beat: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !valid_o);

    a_r8_error_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> !err_o);

    a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i == 3'b000) |=>
            (valid_o && last_o && col_o == $past(start_col_i)));

    a_r9_no_gap: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);

endmodule

bind burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
);

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;
    localparam int COL_W = 9;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input int col, input int code, input int typ, input bit stp);
        start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = 3'(code);
        ilv_i = typ[0]; stop_i = stp;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
    endtask

    task automatic run_burst(input int col, input int code, input int typ);
        int len = 1 << code;
        int off = col % len;
        int base = col - off;
        string req = (len == 1) ? "R5" : (typ != 0 ? "R4" : "R3");
        launch(col, code, typ, 1'b0);
        for (int k = 0; k < len; k++) begin
            int e = (typ != 0) ? base + (off ^ k) : base + ((off + k) % len);
            check(req, "col", int'(col_o), e);
            check("R9", "valid", int'(valid_o), 1);
            check("R2", "last", int'(last_o), (k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R2", "valid after end", int'(valid_o), 0);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "valid", int'(valid_o), 0);
        check("R1", "last", int'(last_o), 0);
        check("R1", "err", int'(err_o), 0);

        // R2 R3 R4 R5 R9: every start column, every block length, both orders
        for (int code = 0; code < 4; code++)
            for (int typ = 0; typ < 2; typ++)
                for (int col = 0; col < NCOL; col++)
                    run_burst(col, code, typ);

        // R6 page burst crossing column zero, then R7 stop
        launch(500, 7, 0, 1'b0);
        for (int k = 0; k < 600; k++) begin
            check("R6", "col", int'(col_o), (500 + k) % NCOL);
            check("R6", "valid", int'(valid_o), 1);
            check("R6", "last", int'(last_o), 0);
            if (k == 599) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        check("R7", "valid after page stop", int'(valid_o), 0);

        // R7 stop inside an eight-beat burst after three beats
        launch(16, 3, 0, 1'b0);
        @(negedge clk); @(negedge clk);
        check("R7", "col before stop", int'(col_o), 18);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check("R7", "valid after stop", int'(valid_o), 0);
        @(negedge clk);
        check("R7", "still idle", int'(valid_o), 0);

        // R8 invalid settings
        for (int code = 4; code < 8; code++) begin
            launch(37, code, (code == 7) ? 1 : 0, 1'b0);
            check("R8", "err", int'(err_o), 1);
            check("R8", "valid", int'(valid_o), 0);
            @(negedge clk);
            check("R8", "err pulse width", int'(err_o), 0);
            check("R8", "no beat later", int'(valid_o), 0);
        end
        // R8 invalid start while a burst runs
        launch(64, 3, 1, 1'b0);
        @(negedge clk);
        launch(64, 5, 0, 1'b0);
        check("R8", "err during burst", int'(err_o), 1);
        check("R8", "burst ended", int'(valid_o), 0);
        @(negedge clk);

        // R10 restart with stop in the same cycle
        launch(10, 3, 0, 1'b0);
        @(negedge clk); @(negedge clk);
        launch(101, 2, 1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            check("R10", "col", int'(col_o), 100 + (1 ^ k));
            check("R10", "valid", int'(valid_o), 1);
            check("R10", "last", int'(last_o), (k == 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R10", "valid after end", int'(valid_o), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule